// File: doc/BRIEF.md
# Instruction Address Match Interrupt Unit

This unit watches the instruction start addresses that a small CPU core presents at decode. It raises a breakpoint-style request just before the instruction at a programmed address runs. There are two compare channels. Each channel holds a match address and has its own enable bit. No global interrupt mask and no priority level gates the request. Software programs the channels through a small register port: a select, write data, a write strobe and a combinational read-back.

When a request is raised, the unit also produces the return value that the core will push on the stack. This value is the matched start address plus a small step, not the true next-instruction address. The decoder marks each start address with a one-bit length class. Class 1 covers 16-bit opcodes and a fixed group of short 8-bit forms (short immediate arithmetic, logic, compare, move and store, multi-register push and pop, short jump and call) and gives a step of two. Class 0 covers every other 8-bit opcode and gives a step of one.

The outgoing request behaves as a valid/ready pair. `irq_req` is valid and `irq_ack` is ready. Once raised, the request and its channel and return value stay frozen until `irq_ack` is sampled high, so the core can apply back-pressure for as long as it needs. The decode side has no ready signal: the unit never stalls decode, and hits that occur while a request is waiting are dropped.

Top module: `addr_match_irq`

## Requirements
- R1: After reset both match registers and the enable register read as zero, and `irq_req` is low.
- R2: A write with `cfg_we`=1 loads the register chosen by `cfg_sel` at the clock edge. Select 0 picks the channel 0 address, select 1 the channel 1 address, and select 2 the enable register, whose bit 0 enables channel 0 and bit 1 enables channel 1. `cfg_rdata` shows the selected register combinationally, zero-extended, and select 3 reads zero.
- R3: A channel hits only when its enable bit is 1, `dec_valid` is 1 and `dec_addr` equals its match address. A disabled channel, or an address presented with `dec_valid`=0, never raises a request.
- R4: A hit in decode cycle N raises `irq_req` at the edge that ends cycle N, so it is high in cycle N+1.
- R5: Along with the request, `irq_pc` is the hit address plus 2 when `dec_long`=1 and plus 1 when `dec_long`=0, modulo 2^20.
- R6: When both channels hit in the same cycle, only one request is raised and `irq_chan` is 0. Otherwise `irq_chan` gives the index of the channel that hit.
- R7: While `irq_req` is high and `irq_ack` is low, `irq_req`, `irq_chan` and `irq_pc` hold their values. `irq_ack` sampled high with the request clears it at that edge.
- R8: Hits that occur while a request is pending, including in the cycle it is acknowledged, are discarded.
- R9: An address equal to the previous valid decode address does not raise a request, even across cycles where `dec_valid` is 0. Presenting a different address re-arms the compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0, 1 match address; 2 enable) |
| cfg_wdata | input | 20 | Register write data |
| cfg_rdata | output | 20 | Selected register value |
| dec_valid | input | 1 | An instruction start address is presented |
| dec_addr | input | 20 | Instruction start address |
| dec_long | input | 1 | Length class: 1 gives a step of 2, 0 gives a step of 1 |
| irq_req | output | 1 | Interrupt request (valid) |
| irq_ack | input | 1 | Request accepted (ready) |
| irq_chan | output | 1 | Channel that raised the request |
| irq_pc | output | 20 | Return value to push |

## Verification
The request, its channel and its return value are all due exactly one edge after the decode cycle that hits. A clear is due one edge after the acknowledge. A register write shows up on the read-back one edge after the strobe, while a change of select shows up in the same cycle. The bench advances a behavioural model through every edge. It drives inputs away from the edge and compares all outputs one time step after each rising edge, so each expected value is checked in the cycle it is due and never earlier.

// File: rtl/amu_pkg.sv
package amu_pkg;
  localparam int unsigned AMU_ADDR_W_DEF = 20;
  localparam int unsigned AMU_NCH_DEF    = 2;

  // step between matched start address and pushed value
  function automatic int unsigned amu_step(input logic long_class);
    return long_class ? 2 : 1;
  endfunction
endpackage

// File: rtl/amu_cfg_regs.sv
module amu_cfg_regs #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned NCH    = 2,
  parameter int unsigned SEL_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      sel,
  input  logic [ADDR_W-1:0]     wdata,
  output logic [ADDR_W-1:0]     rdata,
  output logic [NCH*ADDR_W-1:0] match_flat,
  output logic [NCH-1:0]        en_mask
);
  logic [ADDR_W-1:0] match_q [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_match
    always_ff @(posedge clk) begin
      if (!rst_n)
        match_q[g] <= '0;
      else if (wr_en && sel == SEL_W'(g))
        match_q[g] <= wdata;
    end
    assign match_flat[g*ADDR_W +: ADDR_W] = match_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      en_mask <= '0;
    else if (wr_en && sel == SEL_W'(NCH))
      en_mask <= wdata[NCH-1:0];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++)
      if (sel == SEL_W'(i)) rdata = match_q[i];
    if (sel == SEL_W'(NCH)) rdata[NCH-1:0] = en_mask;
  end
endmodule

// File: rtl/amu_match_chan.sv
module amu_match_chan #(
  parameter int unsigned ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic              armed,
  input  logic              probe_valid,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              hit
);
  assign hit = armed && probe_valid && (probe_addr == ref_addr);
endmodule

// File: rtl/amu_req_ctrl.sv
module amu_req_ctrl
  import amu_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned NCH    = 2,
  parameter int unsigned CHAN_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    hit_vec,
  input  logic              dec_valid,
  input  logic [ADDR_W-1:0] dec_addr,
  input  logic              dec_long,
  input  logic              ack,
  output logic              req,
  output logic [CHAN_W-1:0] chan,
  output logic [ADDR_W-1:0] pc
);
  logic              last_vld;
  logic [ADDR_W-1:0] last_addr;
  logic              fresh;
  logic              fire;
  logic [CHAN_W-1:0] win;

  // lowest index wins
  always_comb begin
    win = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (hit_vec[i]) win = CHAN_W'(i);
  end

  assign fresh = !(last_vld && last_addr == dec_addr);
  assign fire  = (|hit_vec) && fresh && !req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_vld  <= 1'b0;
      last_addr <= '0;
    end else if (dec_valid) begin
      last_vld  <= 1'b1;
      last_addr <= dec_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req  <= 1'b0;
      chan <= '0;
      pc   <= '0;
    end else if (req) begin
      if (ack) req <= 1'b0;
    end else if (fire) begin
      req  <= 1'b1;
      chan <= win;
      pc   <= dec_addr + ADDR_W'(amu_step(dec_long));
    end
  end
endmodule

// File: rtl/addr_match_irq.sv
module addr_match_irq
  import amu_pkg::*;
#(
  parameter int unsigned ADDR_W = AMU_ADDR_W_DEF,
  parameter int unsigned NCH    = AMU_NCH_DEF,
  localparam int unsigned SEL_W  = $clog2(NCH + 2),
  localparam int unsigned CHAN_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              dec_valid,
  input  logic [ADDR_W-1:0] dec_addr,
  input  logic              dec_long,
  output logic              irq_req,
  input  logic              irq_ack,
  output logic [CHAN_W-1:0] irq_chan,
  output logic [ADDR_W-1:0] irq_pc
);
  logic [NCH*ADDR_W-1:0] match_flat;
  logic [NCH-1:0]        en_mask;
  logic [NCH-1:0]        hit_vec;

  amu_cfg_regs #(.ADDR_W(ADDR_W), .NCH(NCH), .SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .rdata(cfg_rdata),
    .match_flat(match_flat), .en_mask(en_mask)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    amu_match_chan #(.ADDR_W(ADDR_W)) u_cmp (
      .ref_addr(match_flat[g*ADDR_W +: ADDR_W]),
      .armed(en_mask[g]),
      .probe_valid(dec_valid),
      .probe_addr(dec_addr),
      .hit(hit_vec[g])
    );
  end

  amu_req_ctrl #(.ADDR_W(ADDR_W), .NCH(NCH), .CHAN_W(CHAN_W)) u_req (
    .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec),
    .dec_valid(dec_valid), .dec_addr(dec_addr), .dec_long(dec_long),
    .ack(irq_ack), .req(irq_req), .chan(irq_chan), .pc(irq_pc)
  );
endmodule

// File: rtl/amu_checker.sv
module amu_checker #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned NCH    = 2,
  parameter int unsigned CHAN_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dec_valid,
  input logic [ADDR_W-1:0] dec_addr,
  input logic              dec_long,
  input logic [NCH-1:0]    en_mask,
  input logic              irq_req,
  input logic              irq_ack,
  input logic [CHAN_W-1:0] irq_chan,
  input logic [ADDR_W-1:0] irq_pc
);
  // R4
  rise_after_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(dec_valid));

  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && en_mask == '0) |=> !irq_req);

  // R5
  pushed_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> irq_pc == ($past(dec_long) ? $past(dec_addr) + ADDR_W'(2)
                                                   : $past(dec_addr) + ADDR_W'(1)));

  // R7
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> (irq_req && $stable(irq_pc) && $stable(irq_chan)));

  // R7
  clear_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> !irq_req);

  // R9
  no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(dec_valid) && dec_addr == $past(dec_addr)) |=> !$rose(irq_req));
endmodule

bind addr_match_irq amu_checker #(.ADDR_W(ADDR_W), .NCH(NCH), .CHAN_W(CHAN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_addr(dec_addr),
  .dec_long(dec_long), .en_mask(en_mask), .irq_req(irq_req), .irq_ack(irq_ack),
  .irq_chan(irq_chan), .irq_pc(irq_pc)
);

// File: tb/addr_match_irq_tb_top.sv
`timescale 1ns/1ps
module addr_match_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [19:0] cfg_wdata = '0;
  logic [19:0] cfg_rdata;
  logic        dec_valid = 1'b0;
  logic [19:0] dec_addr = '0;
  logic        dec_long = 1'b0;
  logic        irq_req;
  logic        irq_ack = 1'b0;
  logic [0:0]  irq_chan;
  logic [19:0] irq_pc;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  addr_match_irq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dec_valid(dec_valid),
    .dec_addr(dec_addr), .dec_long(dec_long), .irq_req(irq_req),
    .irq_ack(irq_ack), .irq_chan(irq_chan), .irq_pc(irq_pc)
  );

  // behavioural reference state
  int unsigned mm0, mm1, men, mlast;
  bit mlast_vld, mreq;
  int unsigned mchan, mpc;

  task automatic chk(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    mm0 = 0; mm1 = 0; men = 0; mlast = 0; mlast_vld = 0; mreq = 0; mchan = 0; mpc = 0;
  endtask

  function automatic int unsigned exp_rdata();
    case (cfg_sel)
      2'd0: return mm0;
      2'd1: return mm1;
      2'd2: return men;
      default: return 0;
    endcase
  endfunction

  task automatic compare(input string tag);
    chk(irq_req == mreq, {tag, " R4 req"}, irq_req, mreq);
    if (mreq) begin
      chk(irq_chan == mchan[0], {tag, " R6 chan"}, irq_chan, mchan);
      chk(irq_pc == mpc[19:0], {tag, " R5 pc"}, irq_pc, mpc);
    end
    chk(cfg_rdata == exp_rdata(), {tag, " R2 rdata"}, cfg_rdata, exp_rdata());
  endtask

  task automatic cycle(input string tag);
    bit h0, h1, fresh;
    int unsigned a = dec_addr;
    h0 = men[0] && dec_valid && a == mm0;
    h1 = men[1] && dec_valid && a == mm1;
    fresh = !(mlast_vld && mlast == a);
    @(posedge clk);
    if (rst_n) begin
      if (mreq) begin
        if (irq_ack) mreq = 0;
      end else if ((h0 || h1) && fresh) begin
        mreq = 1;
        mchan = h0 ? 0 : 1;
        mpc = (a + (dec_long ? 2 : 1)) & 20'hFFFFF;
      end
      if (dec_valid) begin mlast = a; mlast_vld = 1; end
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: mm0 = cfg_wdata;
          2'd1: mm1 = cfg_wdata;
          2'd2: men = cfg_wdata & 3;
          default: ;
        endcase
      end
    end else model_reset();
    #1;
    compare(tag);
  endtask

  task automatic wr(input logic [1:0] s, input logic [19:0] d);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    cycle("wr");
    cfg_we = 0;
  endtask

  task automatic dec(input logic [19:0] a, input logic lng, input string tag);
    dec_valid = 1; dec_addr = a; dec_long = lng;
    cycle(tag);
    dec_valid = 0;
  endtask

  task automatic ack_it();
    irq_ack = 1;
    cycle("ack");
    irq_ack = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) cycle("rst");
    @(negedge clk);
    rst_n = 1;
    // R1: reset values of every register and the request
    for (int s = 0; s < 3; s++) begin
      cfg_sel = 2'(s); #1;
      chk(cfg_rdata == 0, "R1 reg zero", cfg_rdata, 0);
    end
    chk(irq_req == 0, "R1 req low", irq_req, 0);

    // R2: program registers, read back including unused select 3
    wr(2'd0, 20'h12345);
    wr(2'd1, 20'h0ABCD);
    cfg_sel = 2'd3; cycle("R2 sel3");
    cfg_sel = 2'd0; cycle("R2 sel0");
    cfg_sel = 2'd1; cycle("R2 sel1");

    // R3: disabled channel and invalid cycles raise nothing
    dec(20'h12345, 1, "R3 disabled");
    chk(irq_req == 0, "R3 disabled quiet", irq_req, 0);
    wr(2'd2, 20'h00001);
    dec(20'h00010, 0, "other");
    dec_addr = 20'h12345; cycle("R3 invalid");
    chk(irq_req == 0, "R3 invalid quiet", irq_req, 0);

    // R4 R5: hit with long class
    dec(20'h12345, 1, "R4 hit0");
    chk(irq_req == 1 && irq_pc == 20'h12347, "R5 plus two", irq_pc, 20'h12347);
    // R7 R8: hold while other hits arrive
    wr(2'd2, 20'h00003);
    dec(20'h0ABCD, 0, "R8 pending");
    dec(20'h00020, 0, "R8 pending2");
    chk(irq_pc == 20'h12347 && irq_chan == 0, "R7 R8 held", irq_pc, 20'h12347);
    ack_it();
    chk(irq_req == 0, "R7 cleared", irq_req, 0);

    // R5 R6: channel 1 with short class
    dec(20'h0ABCD, 0, "R6 hit1");
    chk(irq_chan == 1 && irq_pc == 20'h0ABCE, "R5 plus one", irq_pc, 20'h0ABCE);
    // R8: hit in the ack cycle discarded
    irq_ack = 1; dec(20'h12345, 0, "R8 ack cycle"); irq_ack = 0;
    chk(irq_req == 0, "R8 ack-cycle hit dropped", irq_req, 0);

    // R9: repeated address does not retrigger, re-arm after a different one
    dec(20'h12345, 0, "R9 repeat");
    chk(irq_req == 0, "R9 no retrigger", irq_req, 0);
    cycle("gap");
    dec(20'h12345, 0, "R9 repeat gap");
    chk(irq_req == 0, "R9 no retrigger gap", irq_req, 0);
    dec(20'h00040, 0, "R9 other");
    dec(20'h12345, 0, "R9 rearm");
    chk(irq_req == 1 && irq_chan == 0, "R9 rearmed", irq_req, 1);
    ack_it();

    // R6: both channels on same address
    wr(2'd1, 20'h12345);
    dec(20'h00050, 0, "x");
    dec(20'h12345, 1, "R6 both");
    chk(irq_req == 1 && irq_chan == 0, "R6 priority ch0", irq_chan, 0);
    ack_it();
    // R3: only channel 1 enabled, same address
    wr(2'd2, 20'h00002);
    dec(20'h00060, 0, "x");
    dec(20'h12345, 1, "R3 ch1 only");
    chk(irq_chan == 1, "R3 ch1 only", irq_chan, 1);
    ack_it();

    // R5: wrap
    wr(2'd1, 20'hFFFFF);
    dec(20'hFFFFF, 1, "R5 wrap");
    chk(irq_pc == 20'h00001, "R5 wrap", irq_pc, 20'h00001);
    repeat (3) cycle("R7 idle hold");
    ack_it();
    repeat (2) cycle("tail");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule